// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces the two port-to-port interrupt flags of a 1024-entry dual-port memory. The two highest addresses serve as mailboxes. Address 0x3FE is the left port's mailbox and address 0x3FF is the right port's mailbox. When one port writes into the other port's mailbox, it raises that other port's flag. The flagged port acknowledges by reading its own mailbox, which drops the flag. The message byte itself is stored in the ordinary memory array next to this block. This block only watches the two ports' control and address lines.

Each port supplies the following inputs:
- an active-low select
- a read/write line (1 = read, 0 = write)
- an active-low output enable
- a 10-bit address
- an active-low BUSY

An action by a port whose BUSY is low is ignored.

Each flag is held by a small state machine with two states, `FLAG_IDLE` and `FLAG_PENDING`:
- Transition `T_RAISE` moves from `FLAG_IDLE` to `FLAG_PENDING` on a valid peer write.
- Transition `T_ACK` moves from `FLAG_PENDING` to `FLAG_IDLE` on a valid owner read with no raise in the same cycle.
- Transition `T_HOLD` keeps the current state in every other case.

The flag output is low exactly in `FLAG_PENDING`. A parameter removes the function. With the function removed, both flags stay high and the mailbox addresses are plain memory.

Top module: `mbx_irq_flags`

## Requirements
- R1: During and right after reset (rst_n low), both l_int_n and r_int_n are high.
- R2: A right-port write to 0x3FE raises the left flag. A write here means r_cs_n=0, r_rw=0 and r_busy_n=1. l_int_n goes low after the next rising clock edge.
- R3: A left-port read of 0x3FE drops the left flag, so l_int_n returns high after the next rising edge. A read here means l_cs_n=0, l_rw=1, l_oe_n=0 and l_busy_n=1.
- R4: A left-port write to 0x3FF, with l_cs_n=0, l_rw=0 and l_busy_n=1, drives r_int_n low after the next rising edge.
- R5: A right-port read of 0x3FF, with r_cs_n=0, r_rw=1, r_oe_n=0 and r_busy_n=1, returns r_int_n high after the next rising edge.
- R6: A raise or an acknowledge is ignored when the acting port's BUSY input is low.
- R7: If a flag's raise and its acknowledge arrive in the same cycle, the raise wins and the flag ends low.
- R8: The following have no effect on either flag:
  - accesses to any other address
  - accesses with select high
  - reads with output enable high
  - a port writing its own mailbox
  - a port reading the peer's mailbox
- R9: With parameter IRQ_EN = 0, both flags stay high whatever the ports do.
- R10: A raised flag stays low across idle cycles until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_cs_n | input | 1 | Left port select, active low |
| l_rw | input | 1 | Left port direction, 1 = read, 0 = write |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | 10 | Left port address |
| l_busy_n | input | 1 | Left port BUSY, active low |
| r_cs_n | input | 1 | Right port select, active low |
| r_rw | input | 1 | Right port direction, 1 = read, 0 = write |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | 10 | Right port address |
| r_busy_n | input | 1 | Right port BUSY, active low |
| l_int_n | output | 1 | Left port interrupt flag, active low |
| r_int_n | output | 1 | Right port interrupt flag, active low |

## Verification
A flag's raise by the peer port and its acknowledge by the owning port can fall in the same cycle. This is provoked by having the right port write 0x3FE while the left port reads 0x3FE, and likewise with the roles of the two ports swapped. Both cases are run with the flag already pending and with it idle. The case is judged correct only if the flag is low after the edge. The scoreboard model and a bound property both encode the raise-wins rule independently of the state machine.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic raise_peer;
        logic ack_own;
    } port_evt_t;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter logic [ADDR_W-1:0] OWN_BOX = '1,
    parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
    input  logic              cs_n,
    input  logic              rw,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_n,
    output port_evt_t         evt
);

    logic selected;
    logic is_write;
    logic is_read;

    always_comb begin
        // The port is active only when selected and not held off by BUSY.
        selected = !cs_n && busy_n;
        is_write = selected && !rw;
        is_read  = selected && rw && !oe_n;
        evt.raise_peer = is_write && (addr == PEER_BOX);
        evt.ack_own    = is_read  && (addr == OWN_BOX);
    end

endmodule

// File: rtl/mbx_flag_fsm.sv
module mbx_flag_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack,
    output logic int_n
);

    flag_state_e state_q;
    flag_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_RAISE, T_ACK, T_HOLD. A raise outranks an acknowledge.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (raise) begin
                    state_d = FLAG_PENDING;   // T_RAISE
                end
            end
            FLAG_PENDING: begin
                if (ack && !raise) begin
                    state_d = FLAG_IDLE;      // T_ACK
                end
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    // Output process.
    always_comb begin
        unique case (state_q)
            FLAG_PENDING: int_n = 1'b0;
            default:      int_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter bit IRQ_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_cs_n,
    input  logic              l_rw,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy_n,
    input  logic              r_cs_n,
    input  logic              r_rw,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy_n,
    output logic              l_int_n,
    output logic              r_int_n
);

    // Top two locations of the array: left mailbox, then right mailbox.
    localparam logic [ADDR_W-1:0] BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};

    generate
        if (IRQ_EN) begin : g_irq
            port_evt_t evt_l;
            port_evt_t evt_r;

            mbx_port_decode #(
                .ADDR_W  (ADDR_W),
                .OWN_BOX (BOX_L),
                .PEER_BOX(BOX_R)
            ) u_dec_l (
                .cs_n  (l_cs_n),
                .rw    (l_rw),
                .oe_n  (l_oe_n),
                .addr  (l_addr),
                .busy_n(l_busy_n),
                .evt   (evt_l)
            );

            mbx_port_decode #(
                .ADDR_W  (ADDR_W),
                .OWN_BOX (BOX_R),
                .PEER_BOX(BOX_L)
            ) u_dec_r (
                .cs_n  (r_cs_n),
                .rw    (r_rw),
                .oe_n  (r_oe_n),
                .addr  (r_addr),
                .busy_n(r_busy_n),
                .evt   (evt_r)
            );

            mbx_flag_fsm u_flag_l (
                .clk  (clk),
                .rst_n(rst_n),
                .raise(evt_r.raise_peer),
                .ack  (evt_l.ack_own),
                .int_n(l_int_n)
            );

            mbx_flag_fsm u_flag_r (
                .clk  (clk),
                .rst_n(rst_n),
                .raise(evt_l.raise_peer),
                .ack  (evt_r.ack_own),
                .int_n(r_int_n)
            );
        end else begin : g_off
            assign l_int_n = 1'b1;
            assign r_int_n = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/mbx_irq_checker.sv
module mbx_irq_checker #(
    parameter int ADDR_W = 10,
    parameter bit IRQ_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_cs_n,
    input logic              l_rw,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_busy_n,
    input logic              r_cs_n,
    input logic              r_rw,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_busy_n,
    input logic              l_int_n,
    input logic              r_int_n
);

    localparam logic [ADDR_W-1:0] CK_BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] CK_BOX_R = {ADDR_W{1'b1}};

    logic raise_l;
    logic ack_l;
    logic raise_r;
    logic ack_r;

    assign raise_l = IRQ_EN && !r_cs_n && !r_rw && r_busy_n && (r_addr == CK_BOX_L);
    assign ack_l   = IRQ_EN && !l_cs_n && l_rw && !l_oe_n && l_busy_n && (l_addr == CK_BOX_L);
    assign raise_r = IRQ_EN && !l_cs_n && !l_rw && l_busy_n && (l_addr == CK_BOX_R);
    assign ack_r   = IRQ_EN && !r_cs_n && r_rw && !r_oe_n && r_busy_n && (r_addr == CK_BOX_R);

    AST_L_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        raise_l |=> !l_int_n); // R2
    AST_L_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_l && !raise_l) |=> l_int_n); // R3
    AST_R_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        raise_r |=> !r_int_n); // R4
    AST_R_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_r && !raise_r) |=> r_int_n); // R5
    AST_L_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_l && ack_l) |=> !l_int_n); // R7
    AST_R_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_r && ack_r) |=> !r_int_n); // R7
    AST_L_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!raise_l && !ack_l) |=> $stable(l_int_n)); // R6
    AST_R_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!raise_r && !ack_r) |=> $stable(r_int_n)); // R8
    AST_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !IRQ_EN |-> (l_int_n && r_int_n)); // R9

endmodule

bind mbx_irq_flags mbx_irq_checker #(
    .ADDR_W(ADDR_W),
    .IRQ_EN(IRQ_EN)
) u_mbx_irq_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_cs_n  (l_cs_n),
    .l_rw    (l_rw),
    .l_oe_n  (l_oe_n),
    .l_addr  (l_addr),
    .l_busy_n(l_busy_n),
    .r_cs_n  (r_cs_n),
    .r_rw    (r_rw),
    .r_oe_n  (r_oe_n),
    .r_addr  (r_addr),
    .r_busy_n(r_busy_n),
    .l_int_n (l_int_n),
    .r_int_n (r_int_n)
);

// File: tb/test_mbx_irq_flags.sv
`timescale 1ns/1ps
module test_mbx_irq_flags;

    localparam int  AW        = 10;
    localparam real PERIOD    = 5.0;
    localparam int  WD_CYCLES = 200000;

    typedef struct {
        logic  exp_l;
        logic  exp_r;
        string tag;
    } sb_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_cs_n = 1'b1, l_rw = 1'b1, l_oe_n = 1'b1, l_busy_n = 1'b1;
    logic          r_cs_n = 1'b1, r_rw = 1'b1, r_oe_n = 1'b1, r_busy_n = 1'b1;
    logic [AW-1:0] l_addr = '0;
    logic [AW-1:0] r_addr = '0;
    logic          l_int_n, r_int_n;
    logic          off_l_int_n, off_r_int_n;

    int checks   = 0;
    int failures = 0;
    logic model_l = 1'b1;
    logic model_r = 1'b1;
    sb_item_t sb[$];

    always #(PERIOD / 2.0) clk = ~clk;

    mbx_irq_flags #(.ADDR_W(AW), .IRQ_EN(1'b1)) i_mbx_irq_flags (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
        .r_cs_n(r_cs_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
        .l_int_n(l_int_n), .r_int_n(r_int_n)
    );

    mbx_irq_flags #(.ADDR_W(AW), .IRQ_EN(1'b0)) i_mbx_irq_flags_off (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
        .r_cs_n(r_cs_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
        .l_int_n(off_l_int_n), .r_int_n(off_r_int_n)
    );

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected flags.
    task automatic drive(
        input logic lcs, input logic lrw, input logic loe, input logic [AW-1:0] la, input logic lbz,
        input logic rcs, input logic rrw, input logic roe, input logic [AW-1:0] ra, input logic rbz,
        input string tag);
        logic set_l, clr_l, set_r, clr_r;
        sb_item_t it;
        @(negedge clk);
        l_cs_n = lcs; l_rw = lrw; l_oe_n = loe; l_addr = la; l_busy_n = lbz;
        r_cs_n = rcs; r_rw = rrw; r_oe_n = roe; r_addr = ra; r_busy_n = rbz;
        set_l = !rcs && !rrw && rbz && (ra == 10'h3FE);
        clr_l = !lcs && lrw && !loe && lbz && (la == 10'h3FE);
        set_r = !lcs && !lrw && lbz && (la == 10'h3FF);
        clr_r = !rcs && rrw && !roe && rbz && (ra == 10'h3FF);
        model_l = set_l ? 1'b0 : (clr_l ? 1'b1 : model_l);
        model_r = set_r ? 1'b0 : (clr_r ? 1'b1 : model_r);
        it.exp_l = model_l;
        it.exp_r = model_r;
        it.tag   = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input string tag);
        drive(1'b1, 1'b1, 1'b1, 10'h000, 1'b1, 1'b1, 1'b1, 1'b1, 10'h000, 1'b1, tag);
    endtask

    // Monitor: compares one expected item per cycle, shortly after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                sb_item_t it;
                it = sb.pop_front();
                check(l_int_n, it.exp_l, {it.tag, " l_int_n"});
                check(r_int_n, it.exp_r, {it.tag, " r_int_n"});
                check(off_l_int_n, 1'b1, "R9 disabled l_int_n");
                check(off_r_int_n, 1'b1, "R9 disabled r_int_n");
            end
        end
    end

    initial begin
        #(PERIOD * WD_CYCLES);
        failures++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(l_int_n, 1'b1, "R1 reset l_int_n");
        check(r_int_n, 1'b1, "R1 reset r_int_n");
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(l_int_n, 1'b1, "R1 after reset l_int_n");
        check(r_int_n, 1'b1, "R1 after reset r_int_n");

        // lcs lrw loe laddr lbz | rcs rrw roe raddr rbz
        drive(1,1,1,10'h000,1, 0,0,1,10'h3FE,1, "R2 right writes left box");
        idle("R10 hold pending");
        idle("R10 hold pending again");
        drive(0,1,1,10'h3FE,1, 1,1,1,10'h000,1, "R8 read with oe high");
        drive(0,1,0,10'h3FE,0, 1,1,1,10'h000,1, "R6 left ack while busy");
        drive(0,1,0,10'h3FF,1, 1,1,1,10'h000,1, "R8 left reads peer box");
        drive(0,1,0,10'h3FE,1, 1,1,1,10'h000,1, "R3 left ack");
        drive(0,0,1,10'h3FF,1, 1,1,1,10'h000,1, "R4 left writes right box");
        drive(1,1,1,10'h000,1, 0,0,1,10'h3FF,1, "R8 right writes own box");
        drive(1,1,1,10'h000,1, 0,1,0,10'h3FD,1, "R8 right reads other address");
        drive(1,1,1,10'h000,1, 0,1,0,10'h3FF,0, "R6 right ack while busy");
        drive(1,1,1,10'h000,1, 0,1,0,10'h3FF,1, "R5 right ack");
        drive(1,1,1,10'h000,1, 0,0,1,10'h3FE,0, "R6 right raise while busy");
        drive(1,0,1,10'h3FF,1, 1,1,1,10'h000,1, "R8 left write deselected");
        drive(0,0,1,10'h3FE,1, 1,1,1,10'h000,1, "R8 left writes own box");
        drive(1,1,1,10'h000,1, 0,0,1,10'h3FD,1, "R8 right writes other address");
        drive(0,1,0,10'h3FE,1, 0,0,1,10'h3FE,1, "R7 left raise and ack from idle");
        drive(0,1,0,10'h3FE,1, 0,0,1,10'h3FE,1, "R7 left raise and ack when pending");
        drive(0,1,0,10'h3FE,1, 1,1,1,10'h000,1, "R3 left ack after collision");
        drive(0,0,1,10'h3FF,1, 0,1,0,10'h3FF,1, "R7 right raise and ack from idle");
        drive(0,0,1,10'h3FF,1, 0,1,0,10'h3FF,1, "R7 right raise and ack when pending");
        drive(1,1,1,10'h000,1, 0,1,0,10'h3FF,1, "R5 right ack after collision");
        drive(0,0,1,10'h3FF,1, 0,0,1,10'h3FE,1, "R2 R4 both raised together");
        idle("R10 both held");
        drive(0,1,0,10'h3FE,1, 0,1,0,10'h3FF,1, "R3 R5 both acked together");
        idle("R8 quiet end");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule